// File: doc/BRIEF.md
# Integer Execute Stage with Condition Flags

This block is the arithmetic heart of a small load/store integer pipeline. In a single combinational pass it takes a decoded operation and two register operands and produces either an arithmetic result or a memory address. Four operations are supported:

- an add of a 12-bit unsigned immediate;
- a register-register add that sets the flags;
- a register-register subtract that sets the flags;
- an address computation that adds a signed 9-bit offset to a base register.

Only the two flag-setting operations change the four stored condition bits: negative, zero, carry and overflow. The negative and overflow bits are kept apart, so a later signed less-than test can compare them.

Operations enter on a valid/ready stream and leave on a valid/ready stream. The stage holds no data, so it adds no latency. The result is valid in the same cycle the operation is presented. Back-pressure passes straight through: `in_ready` follows `out_ready`. An operation counts as accepted only in a cycle where `in_valid` and `out_ready` are both high, and only an accepted flag-setting operation loads the flag register. While the consumer stalls, the upstream side must hold the operation steady and the flags do not move.

Top module: `exu_core`

## Requirements
- R1: With op code 0 (immediate add), `result` equals `opnd_a` plus `imm_add` zero-extended to the data width, modulo 2^DATA_W.
- R2: With op code 1 (flag-setting add), `result` equals `opnd_a + opnd_b` modulo 2^DATA_W.
- R3: With op code 2 (flag-setting subtract), `result` equals `opnd_a - opnd_b` modulo 2^DATA_W.
- R4: With op code 3 (address generation), `result` equals `opnd_a` plus `imm_mem` sign-extended from its top bit, modulo 2^DATA_W.
- R5: After an accepted flag-setting operation, `flag_n` equals the top bit of that operation's result, and `flag_z` is 1 exactly when all result bits were 0.
- R6: After an accepted add, `flag_c` is the unsigned carry out of the top bit. After an accepted subtract, `flag_c` is 1 exactly when `opnd_a >= opnd_b` unsigned, which is the carry of a + ~b + 1.
- R7: After an accepted flag-setting operation, `flag_v` is 1 exactly when the two's-complement result of the add or subtract lies outside the signed range of the data width.
- R8: The flags hold their value across any clock edge without an accepted flag-setting operation. This covers immediate add, address generation, `in_valid` low, and `out_ready` low.
- R9: A synchronous active-high `rst` clears all four flags on the next clock edge, taking priority over any operation presented in that cycle.
- R10: `out_valid` follows `in_valid` and `in_ready` follows `out_ready` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flags |
| in_valid | input | 1 | An operation is presented |
| in_ready | output | 1 | Stage can accept (mirrors out_ready) |
| op | input | 2 | Operation: 0 imm add, 1 add+flags, 2 sub+flags, 3 address |
| opnd_a | input | DATA_W | First register operand / base register |
| opnd_b | input | DATA_W | Second register operand |
| imm_add | input | IMM_A_W | Unsigned immediate for op 0 |
| imm_mem | input | IMM_M_W | Signed offset for op 3 |
| out_valid | output | 1 | Result is valid (mirrors in_valid) |
| out_ready | input | 1 | Consumer accepts the result |
| result | output | DATA_W | Sum, difference or address |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry flag |
| flag_v | output | 1 | Stored overflow flag |

## Verification
The only state in this block is the four-bit flag register. A corrupted flag bit, or a load that fires when it should not, is visible on the flag pins one clock edge after the offending cycle. It then stays visible until the next accepted flag-setting operation overwrites it.

A fault in the operand selection or in the adder shows up directly on `result` in the same cycle, with no register in between. It is also captured into the flags at the next edge.

Full sweeps over a narrow build of the block expose every carry, borrow and sign-overflow boundary. Directed 64-bit cases cover the extreme values and the stall behaviour.

// File: rtl/exu_pkg.sv
package exu_pkg;

  typedef enum logic [1:0] {
    EXU_ADDI = 2'd0,
    EXU_ADDS = 2'd1,
    EXU_SUBS = 2'd2,
    EXU_AGEN = 2'd3
  } exu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } exu_flags_t;

  function automatic logic exu_sets_flags(input exu_op_e o);
    return (o == EXU_ADDS) || (o == EXU_SUBS);
  endfunction

endpackage

// File: rtl/exu_operand_sel.sv
module exu_operand_sel #(
  parameter int DATA_W  = 64,
  parameter int IMM_A_W = 12,
  parameter int IMM_M_W = 9
) (
  input  exu_pkg::exu_op_e     op,
  input  logic [DATA_W-1:0]    opnd_b,
  input  logic [IMM_A_W-1:0]   imm_add,
  input  logic [IMM_M_W-1:0]   imm_mem,
  output logic [DATA_W-1:0]    addend,
  output logic                 carry_in
);
  import exu_pkg::*;

  localparam int ZPAD = DATA_W - IMM_A_W;
  localparam int SPAD = DATA_W - IMM_M_W;

  logic [DATA_W-1:0] imm_a_ext;
  logic [DATA_W-1:0] imm_m_ext;

  generate
    if (ZPAD > 0) begin : g_zext
      assign imm_a_ext = {{ZPAD{1'b0}}, imm_add};
    end else begin : g_ztrunc
      assign imm_a_ext = imm_add[DATA_W-1:0];
    end
    if (SPAD > 0) begin : g_sext
      assign imm_m_ext = {{SPAD{imm_mem[IMM_M_W-1]}}, imm_mem};
    end else begin : g_strunc
      assign imm_m_ext = imm_mem[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    carry_in = 1'b0;
    unique case (op)
      EXU_ADDI: addend = imm_a_ext;
      EXU_ADDS: addend = opnd_b;
      EXU_SUBS: begin
        addend   = ~opnd_b;
        carry_in = 1'b1;
      end
      default:  addend = imm_m_ext;
    endcase
  end

endmodule

// File: rtl/exu_adder.sv
module exu_adder #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              cout,
  output logic              ovf
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0] wide;

  always_comb begin
    wide = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
    sum  = wide[MSB:0];
    cout = wide[DATA_W];
    ovf  = (x[MSB] == y[MSB]) && (wide[MSB] != x[MSB]);
  end

endmodule

// File: rtl/exu_flag_reg.sv
module exu_flag_reg (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  exu_pkg::exu_flags_t nxt,
  output exu_pkg::exu_flags_t cur
);

  always_ff @(posedge clk) begin
    if (rst)       cur <= '0;
    else if (load) cur <= nxt;
  end

endmodule

// File: rtl/exu_core.sv
module exu_core #(
  parameter int DATA_W  = 64,
  parameter int IMM_A_W = 12,
  parameter int IMM_M_W = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [1:0]         op,
  input  logic [DATA_W-1:0]  opnd_a,
  input  logic [DATA_W-1:0]  opnd_b,
  input  logic [IMM_A_W-1:0] imm_add,
  input  logic [IMM_M_W-1:0] imm_mem,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DATA_W-1:0]  result,
  output logic               flag_n,
  output logic               flag_z,
  output logic               flag_c,
  output logic               flag_v
);
  import exu_pkg::*;

  exu_op_e           op_q;
  logic [DATA_W-1:0] addend;
  logic              cin;
  logic [DATA_W-1:0] sum;
  logic              cout;
  logic              ovf;
  logic              accept;
  exu_flags_t        flags_nxt;
  exu_flags_t        flags_cur;

  assign op_q = exu_op_e'(op);

  exu_operand_sel #(
    .DATA_W (DATA_W),
    .IMM_A_W(IMM_A_W),
    .IMM_M_W(IMM_M_W)
  ) u_sel (
    .op      (op_q),
    .opnd_b  (opnd_b),
    .imm_add (imm_add),
    .imm_mem (imm_mem),
    .addend  (addend),
    .carry_in(cin)
  );

  exu_adder #(.DATA_W(DATA_W)) u_add (
    .x   (opnd_a),
    .y   (addend),
    .cin (cin),
    .sum (sum),
    .cout(cout),
    .ovf (ovf)
  );

  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign accept    = in_valid && out_ready;
  assign result    = sum;

  always_comb begin
    flags_nxt.n = sum[DATA_W-1];
    flags_nxt.z = (sum == '0);
    flags_nxt.c = cout;
    flags_nxt.v = ovf;
  end

  exu_flag_reg u_flags (
    .clk (clk),
    .rst (rst),
    .load(accept && exu_sets_flags(op_q)),
    .nxt (flags_nxt),
    .cur (flags_cur)
  );

  assign flag_n = flags_cur.n;
  assign flag_z = flags_cur.z;
  assign flag_c = flags_cur.c;
  assign flag_v = flags_cur.v;

endmodule

// File: rtl/exu_checker.sv
module exu_checker #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              out_ready,
  input logic [1:0]        op,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic [DATA_W-1:0] result,
  input logic              flag_n,
  input logic              flag_z,
  input logic              flag_c,
  input logic              flag_v
);
  logic fire_flag;
  assign fire_flag = in_valid && out_ready && (op == 2'd1 || op == 2'd2);

  // R8: flags hold without an accepted flag-setting operation
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !fire_flag |=> $stable({flag_n, flag_z, flag_c, flag_v}));

  // R9: reset clears every flag
  p_clear_r9: assert property (@(posedge clk)
    rst |=> ({flag_n, flag_z, flag_c, flag_v} == 4'b0000));

  // R5: zero flag mirrors the captured result
  p_zero_r5: assert property (@(posedge clk) disable iff (rst)
    fire_flag |=> (flag_z == ($past(result) == '0)));

  // R5: negative flag mirrors the captured sign bit
  p_neg_r5: assert property (@(posedge clk) disable iff (rst)
    fire_flag |=> (flag_n == $past(result[DATA_W-1])));

  // R6: subtract carry means no unsigned borrow
  p_borrow_r6: assert property (@(posedge clk) disable iff (rst)
    (fire_flag && op == 2'd2) |=> (flag_c == ($past(opnd_a) >= $past(opnd_b))));

endmodule

bind exu_core exu_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .out_ready(out_ready),
  .op       (op),
  .opnd_a   (opnd_a),
  .opnd_b   (opnd_b),
  .result   (result),
  .flag_n   (flag_n),
  .flag_z   (flag_z),
  .flag_c   (flag_c),
  .flag_v   (flag_v)
);

// File: tb/sim_exu_core.sv
`timescale 1ns/1ps
module sim_exu_core;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;

  // 64-bit instance
  logic        v0 = 0, r0 = 1;
  logic [1:0]  op0 = 0;
  logic [63:0] a0 = 0, b0 = 0;
  logic [11:0] i12 = 0;
  logic [8:0]  i9 = 0;
  logic        irdy0, ov0;
  logic [63:0] res0;
  logic        n0, z0, c0, fv0;

  exu_core u0 (
    .clk(clk), .rst(rst), .in_valid(v0), .in_ready(irdy0), .op(op0),
    .opnd_a(a0), .opnd_b(b0), .imm_add(i12), .imm_mem(i9),
    .out_valid(ov0), .out_ready(r0), .result(res0),
    .flag_n(n0), .flag_z(z0), .flag_c(c0), .flag_v(fv0)
  );

  // narrow instance for sweeps
  logic       v1 = 0;
  logic [1:0] op1 = 0;
  logic [5:0] a1 = 0, b1 = 0;
  logic [2:0] ia1 = 0, im1 = 0;
  logic       irdy1, ov1;
  logic [5:0] res1;
  logic       n1, z1, c1, fv1;

  exu_core #(.DATA_W(6), .IMM_A_W(3), .IMM_M_W(3)) u1 (
    .clk(clk), .rst(rst), .in_valid(v1), .in_ready(irdy1), .op(op1),
    .opnd_a(a1), .opnd_b(b1), .imm_add(ia1), .imm_mem(im1),
    .out_valid(ov1), .out_ready(1'b1), .result(res1),
    .flag_n(n1), .flag_z(z1), .flag_c(c1), .flag_v(fv1)
  );

  logic [3:0] mf0 = 0;   // model flags {n,z,c,v}
  logic [3:0] mf1 = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one operation on the 64-bit unit and check it
  task automatic run0(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b,
                      input logic [11:0] ia, input logic [8:0] im,
                      input logic v, input logic rdy, input string req);
    logic [64:0] us;
    logic signed [64:0] ss;
    logic [63:0] er;
    logic [3:0] nf;
    @(negedge clk);
    op0 = op; a0 = a; b0 = b; i12 = ia; i9 = im; v0 = v; r0 = rdy;
    #1;
    case (op)
      2'd0: er = a + {52'd0, ia};
      2'd1: er = a + b;
      2'd2: er = a - b;
      default: er = a + {{55{im[8]}}, im};
    endcase
    chk(res0 == er, req, res0, er);
    chk(ov0 == v && irdy0 == rdy, "R10", {ov0, irdy0}, {v, rdy});
    if (op == 2'd1) begin
      us = {1'b0, a} + {1'b0, b};
      ss = $signed({a[63], a}) + $signed({b[63], b});
      nf = {er[63], er == 0, us[64], ss[64] != ss[63]};
    end else begin
      ss = $signed({a[63], a}) - $signed({b[63], b});
      nf = {er[63], er == 0, a >= b, ss[64] != ss[63]};
    end
    if (v && rdy && (op == 2'd1 || op == 2'd2)) mf0 = nf;
    @(posedge clk); #1;
    chk({n0, z0, c0, fv0} == mf0, req, {n0, z0, c0, fv0}, mf0);
  endtask

  task automatic run1(input logic [1:0] op, input int a, input int b, input int ia, input int im);
    int sa, sb, sr, er, si;
    @(negedge clk);
    v1 = 1; op1 = op; a1 = a[5:0]; b1 = b[5:0]; ia1 = ia[2:0]; im1 = im[2:0];
    #1;
    sa = (a >= 32) ? a - 64 : a;
    sb = (b >= 32) ? b - 64 : b;
    si = (im >= 4) ? im - 8 : im;
    case (op)
      2'd0: begin er = (a + ia) % 64;       chk(res1 == er[5:0], "R1", res1, er); end
      2'd1: begin
        er = (a + b) % 64; sr = sa + sb;
        chk(res1 == er[5:0], "R2", res1, er);
        mf1 = {er >= 32, er == 0, (a + b) > 63, (sr > 31) || (sr < -32)};
      end
      2'd2: begin
        er = (a - b + 64) % 64; sr = sa - sb;
        chk(res1 == er[5:0], "R3", res1, er);
        mf1 = {er >= 32, er == 0, a >= b, (sr > 31) || (sr < -32)};
      end
      default: begin er = (a + si + 64) % 64; chk(res1 == er[5:0], "R4", res1, er); end
    endcase
    @(posedge clk); #1;
    chk({n1, z1, c1, fv1} == mf1, "R5 R6 R7 R8", {n1, z1, c1, fv1}, mf1);
  endtask

  localparam logic [63:0] MAXU = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MAXS = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MINS = 64'h8000_0000_0000_0000;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk({n0, z0, c0, fv0} == 4'b0, "R9 reset state", {n0, z0, c0, fv0}, 0);
    @(negedge clk); rst = 0;

    run0(2'd1, MAXU, 64'd1, 0, 0, 1, 1, "R2 R5 R6 carry wrap");
    run0(2'd1, MAXS, 64'd1, 0, 0, 1, 1, "R7 add overflow");
    run0(2'd2, 64'd42, 64'd42, 0, 0, 1, 1, "R3 R6 sub equal");
    run0(2'd2, 64'd0, 64'd1, 0, 0, 1, 1, "R3 R6 borrow");
    run0(2'd2, MINS, 64'd1, 0, 0, 1, 1, "R7 sub overflow");
    run0(2'd0, 64'd5, 64'd9, 12'hFFF, 0, 1, 1, "R1 R8 zext imm");
    run0(2'd3, 64'd1000, 64'd0, 0, 9'h1FF, 1, 1, "R4 R8 neg offset");
    run0(2'd3, 64'd0, 64'd0, 0, 9'h100, 1, 1, "R4 min offset");
    run0(2'd3, 64'd7, 64'd0, 0, 9'h0FF, 1, 1, "R4 max offset");
    run0(2'd1, 64'd0, 64'd0, 0, 0, 1, 0, "R8 R10 stalled");
    run0(2'd2, 64'd3, 64'd3, 0, 0, 0, 1, "R8 R10 no valid");
    run0(2'd1, 64'h1234, 64'h1, 0, 0, 1, 1, "R2 plain add");

    // R9: reset wins over a flag-setting op in the same cycle
    run0(2'd2, 64'd0, 64'd1, 0, 0, 1, 1, "R9 preload");
    @(negedge clk);
    rst = 1; op0 = 2'd2; a0 = 0; b0 = 1; v0 = 1; r0 = 1;
    @(posedge clk); #1;
    chk({n0, z0, c0, fv0} == 4'b0, "R9 mid-run reset", {n0, z0, c0, fv0}, 0);
    mf0 = 0; mf1 = 0;
    @(negedge clk); rst = 0; v0 = 0;

    // exhaustive sweeps on the narrow build
    for (int o = 1; o <= 2; o++)
      for (int a = 0; a < 64; a++)
        for (int b = 0; b < 64; b++)
          run1(o[1:0], a, b, 0, 0);
    for (int a = 0; a < 64; a++)
      for (int i = 0; i < 8; i++) begin
        run1(2'd0, a, 0, i, 0);
        run1(2'd3, a, 0, 0, i);
      end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule